// File: doc/BRIEF.md
# PHY Management Register Responder

This block stands in for the management side of an Ethernet PHY. A host reaches it through two words: a command word and a data word. The host first writes the data word if it is issuing a write. It then writes the command word, which carries a PHY address, a register index and a direction flag. When the address matches the block's configured PHY address, the access happens on the same clock edge that stores the command. A read loads the selected register into the data word. A write copies the data word into the control or advertisement register.

The block holds six management registers: control, status, two identifier words, advertisement and link-partner ability. Status reports a fixed set of abilities plus a link-up bit, which follows an external link input one clock later. Writing control with its top bit set performs a PHY self-reset. This restores the control defaults and leaves the advertisement register and the link bit untouched. The identifier and link-partner registers read as hardwired constants.

Top module: `phy_mgmt_responder`

## Requirements
- R1: A write of the command word stores the written value with bit 0 (busy) forced to 0. The stored word is visible on `cmd_o` after the edge. The command fields are: PHY address in bits 15:12, register index in bits 7:4, and write flag in bit 1 (1 = write, 0 = read).
- R2: A command whose address field differs from parameter `PHY_ADDR` changes neither the data word nor any management register. The command word itself is still stored.
- R3: A read of index 2 loads 0x0044 into the data word, and a read of index 3 loads 0x1400.
- R4: After reset, `cmd_o` and `data_o` are 0, control holds 0x3100 (bits 13, 12 and 8 set) and advertisement holds 0.
- R5: A read of index 1 (status) loads 0xFE28 with bit 2 equal to the registered link state. Bits 15 to 9 are abilities, bit 5 is autonegotiation complete and bit 3 is autonegotiation available.
- R6: Status bit 2 takes the value of `link_i` at each clock edge, with no command needed. A status read on the same edge as a change of `link_i` returns the value from before that edge.
- R7: A write of index 0 (control) with data bit 15 clear stores the data with bits 15 and 9 forced to 0.
- R8: A write of index 0 with data bit 15 set restores control to 0x3100. Advertisement and the link bit keep their values.
- R9: A write of index 4 stores all 16 data bits in advertisement, and a read of index 4 returns them.
- R10: A read of index 5 loads 0x0DE0 (bits 5, 6, 7, 8, 10 and 11 set).
- R11: Writes to indices 1, 2, 3 and 5, and writes to indices 6 to 15, leave every register unchanged. A read of indices 6 to 15 leaves the data word unchanged.
- R12: A host write of the data word (`host_sel_cmd` = 0) stores the 16-bit value on `data_o` after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe |
| host_sel_cmd | input | 1 | 1 selects the command word, 0 selects the data word |
| host_wdata | input | 16 | Host write value |
| link_i | input | 1 | External link-up indication |
| cmd_o | output | 16 | Stored command word |
| data_o | output | 16 | Data word (host value or read result) |

## Verification
Two events can land on the same edge: the link bit sampling `link_i`, and a status read or a control self-reset. The bench provokes this by changing `link_i` in the same cycle that it issues such a command. A status read must return the link state from before that edge. After a self-reset, the following status read must show the new link value, which confirms that the reset neither froze nor cleared the link bit. A reference model in the bench tracks the link bit edge by edge and judges these cases together with randomly mixed commands.

// File: rtl/phymgmt_pkg.sv
package phymgmt_pkg;

    localparam int DW = 16;
    localparam int AW = 4;
    localparam int IW = 4;

    localparam logic [IW-1:0] IDX_CTL  = 4'd0;
    localparam logic [IW-1:0] IDX_STAT = 4'd1;
    localparam logic [IW-1:0] IDX_IDH  = 4'd2;
    localparam logic [IW-1:0] IDX_IDL  = 4'd3;
    localparam logic [IW-1:0] IDX_ADV  = 4'd4;
    localparam logic [IW-1:0] IDX_LPA  = 4'd5;

    localparam logic [DW-1:0] CTL_DEFAULT = 16'h3100;
    localparam logic [DW-1:0] CTL_KEEP    = 16'h7DFF;
    localparam int            CTL_SRST    = 15;
    localparam logic [DW-1:0] STAT_FIXED  = 16'hFE28;
    localparam int            STAT_LINK   = 2;
    localparam logic [DW-1:0] ID_HI_VAL   = 16'h0044;
    localparam logic [DW-1:0] ID_LO_VAL   = 16'h1400;
    localparam logic [DW-1:0] LPA_VAL     = 16'h0DE0;

    typedef struct packed {
        logic          hit;
        logic          wr;
        logic [IW-1:0] idx;
    } mgmt_cmd_t;

    function automatic logic idx_known(input logic [IW-1:0] idx);
        return idx <= IDX_LPA;
    endfunction

    function automatic logic [DW-1:0] read_value(input logic [IW-1:0] idx,
                                                 input logic [DW-1:0] cr,
                                                 input logic [DW-1:0] adv,
                                                 input logic link);
        logic [DW-1:0] v;
        case (idx)
            IDX_CTL:  v = cr;
            IDX_STAT: begin
                v = STAT_FIXED;
                v[STAT_LINK] = link;
            end
            IDX_IDH:  v = ID_HI_VAL;
            IDX_IDL:  v = ID_LO_VAL;
            IDX_ADV:  v = adv;
            IDX_LPA:  v = LPA_VAL;
            default:  v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/phymgmt_cmd_decode.sv
module phymgmt_cmd_decode
    import phymgmt_pkg::*;
#(
    parameter logic [AW-1:0] PHY_ADDR = 4'h1
) (
    input  logic [DW-1:0] word_i,
    output mgmt_cmd_t     cmd_o
);
    always_comb begin
        cmd_o.hit = (word_i[15:12] == PHY_ADDR);
        cmd_o.wr  = word_i[1];
        cmd_o.idx = word_i[7:4];
    end
endmodule

// File: rtl/phymgmt_regfile.sv
module phymgmt_regfile
    import phymgmt_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_ctl_i,
    input  logic          self_rst_i,
    input  logic          wr_adv_i,
    input  logic [DW-1:0] wval_i,
    input  logic          link_i,
    output logic [DW-1:0] cr_o,
    output logic [DW-1:0] adv_o,
    output logic          link_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cr_o   <= CTL_DEFAULT;
            adv_o  <= '0;
            link_o <= 1'b0;
        end else begin
            link_o <= link_i;
            if (self_rst_i)
                cr_o <= CTL_DEFAULT;
            else if (wr_ctl_i)
                cr_o <= wval_i & CTL_KEEP;
            if (wr_adv_i)
                adv_o <= wval_i;
        end
    end

    // R6: link bit follows the input one edge later
    p_link_follow_r6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> link_o == $past(link_i));

    // R7: plain control write masks bits 15 and 9
    p_ctl_mask_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_ctl_i && !self_rst_i) |=> cr_o == ($past(wval_i) & CTL_KEEP));

    // R8: self-reset restores defaults and leaves advertisement alone
    p_self_rst_r8: assert property (@(posedge clk) disable iff (rst)
        (self_rst_i && !wr_adv_i) |=> (cr_o == CTL_DEFAULT) && $stable(adv_o));
endmodule

// File: rtl/phy_mgmt_responder.sv
module phy_mgmt_responder
    import phymgmt_pkg::*;
#(
    parameter logic [AW-1:0] PHY_ADDR = 4'h1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          host_we,
    input  logic          host_sel_cmd,
    input  logic [15:0]   host_wdata,
    input  logic          link_i,
    output logic [15:0]   cmd_o,
    output logic [15:0]   data_o
);
    mgmt_cmd_t     dec;
    logic          cmd_go, do_wr, do_rd;
    logic [DW-1:0] cr, adv;
    logic          link;
    logic [DW-1:0] data_q, cmd_q;

    phymgmt_cmd_decode #(.PHY_ADDR(PHY_ADDR)) dec_i (
        .word_i (host_wdata),
        .cmd_o  (dec)
    );

    assign cmd_go = host_we && host_sel_cmd;
    assign do_wr  = cmd_go && dec.hit && dec.wr;
    assign do_rd  = cmd_go && dec.hit && !dec.wr;

    phymgmt_regfile rf_i (
        .clk        (clk),
        .rst        (rst),
        .wr_ctl_i   (do_wr && dec.idx == IDX_CTL && !data_q[CTL_SRST]),
        .self_rst_i (do_wr && dec.idx == IDX_CTL && data_q[CTL_SRST]),
        .wr_adv_i   (do_wr && dec.idx == IDX_ADV),
        .wval_i     (data_q),
        .link_i     (link_i),
        .cr_o       (cr),
        .adv_o      (adv),
        .link_o     (link)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            cmd_q  <= '0;
        end else begin
            if (cmd_go)
                cmd_q <= {host_wdata[DW-1:1], 1'b0};
            if (host_we && !host_sel_cmd)
                data_q <= host_wdata;
            else if (do_rd && idx_known(dec.idx))
                data_q <= read_value(dec.idx, cr, adv, link);
        end
    end

    assign cmd_o  = cmd_q;
    assign data_o = data_q;

    // R1: stored command equals written word with busy cleared
    p_busy_clear_r1: assert property (@(posedge clk) disable iff (rst)
        cmd_go |=> cmd_o == ($past(host_wdata) & 16'hFFFE));

    // R2: foreign address leaves the data word alone
    p_addr_miss_r2: assert property (@(posedge clk) disable iff (rst)
        (cmd_go && host_wdata[15:12] != PHY_ADDR) |=> $stable(data_o));

    // R11: read of an unknown index leaves the data word alone
    p_unknown_read_r11: assert property (@(posedge clk) disable iff (rst)
        (cmd_go && !host_wdata[1] && host_wdata[7:4] > IDX_LPA) |=> $stable(data_o));
endmodule

// File: tb/phy_mgmt_responder_tb_top.sv
`timescale 1ns/1ps
module phy_mgmt_responder_tb_top;
    localparam logic [3:0] PA = 4'h1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_we = 1'b0;
    logic        host_sel_cmd = 1'b0;
    logic [15:0] host_wdata = '0;
    logic        link_i = 1'b0;
    logic [15:0] cmd_o, data_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [15:0] m_cr, m_adv, m_data, m_cmd;
    logic        m_link;

    always #2.5 clk = ~clk;

    phy_mgmt_responder #(.PHY_ADDR(PA)) dut_i (
        .clk(clk), .rst(rst), .host_we(host_we), .host_sel_cmd(host_sel_cmd),
        .host_wdata(host_wdata), .link_i(link_i), .cmd_o(cmd_o), .data_o(data_o)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_read(input logic [3:0] idx);
        case (idx)
            4'd0: return m_cr;
            4'd1: return 16'hFE28 | (16'(m_link) << 2);
            4'd2: return 16'h0044;
            4'd3: return 16'h1400;
            4'd4: return m_adv;
            default: return 16'h0DE0;
        endcase
    endfunction

    task automatic op_idle(input bit lk);
        host_we = 0; link_i = lk;
        @(posedge clk);
        m_link = lk;
        @(negedge clk);
    endtask

    task automatic op_data(input logic [15:0] v, input bit lk);
        host_we = 1; host_sel_cmd = 0; host_wdata = v; link_i = lk;
        @(posedge clk);
        m_data = v; m_link = lk;
        @(negedge clk);
        host_we = 0;
        check("R12 data write", data_o, m_data);
    endtask

    task automatic op_cmd(input logic [15:0] w, input bit lk, input string tag);
        logic [3:0] idx;
        idx = w[7:4];
        host_we = 1; host_sel_cmd = 1; host_wdata = w; link_i = lk;
        @(posedge clk);
        m_cmd = w & 16'hFFFE;
        if (w[15:12] == PA) begin
            if (w[1]) begin
                if (idx == 4'd0) m_cr = m_data[15] ? 16'h3100 : (m_data & 16'h7DFF);
                else if (idx == 4'd4) m_adv = m_data;
            end else if (idx <= 4'd5) begin
                m_data = exp_read(idx);
            end
        end
        m_link = lk;
        @(negedge clk);
        host_we = 0;
        check("R1 command word", cmd_o, m_cmd);
        check(tag, data_o, m_data);
    endtask

    function automatic logic [15:0] mk(input logic [3:0] a, input logic [3:0] idx, input bit wr);
        return {a, 4'h0, idx, 2'b00, wr, 1'b0};
    endfunction

    initial begin
        void'($urandom(32'h5EED1234));
        m_cr = 16'h3100; m_adv = 0; m_data = 0; m_cmd = 0; m_link = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        check("R4 reset data", data_o, 16'h0000);
        check("R4 reset cmd", cmd_o, 16'h0000);
        op_cmd(mk(PA, 0, 0), 0, "R4 control default");
        op_cmd(mk(PA, 4, 0), 0, "R4 advertisement default");
        op_cmd(mk(PA, 1, 0), 0, "R5 status link down");
        op_idle(1);
        op_cmd(mk(PA, 1, 0), 1, "R6 link follows input");
        op_cmd(mk(PA, 1, 0), 0, "R6 same-edge status read sees old link");
        op_cmd(mk(PA, 1, 0), 0, "R5 status after link drop");
        op_cmd(mk(PA, 2, 0), 0, "R3 id high");
        op_cmd(mk(PA, 3, 0), 0, "R3 id low");
        op_cmd(mk(PA, 5, 0), 0, "R10 link partner");
        op_data(16'hABCD, 0);
        op_cmd(mk(PA, 4, 1), 0, "R9 adv write");
        op_data(16'h0000, 0);
        op_cmd(mk(PA, 4, 0), 0, "R9 adv readback");
        op_data(16'h7FFF, 0);
        op_cmd(mk(PA, 0, 1), 0, "R7 ctl write");
        op_cmd(mk(PA, 0, 0), 0, "R7 ctl masked readback");
        op_data(16'hFFFF, 0);
        op_cmd(mk(PA, 0, 1), 1, "R8 self reset with link change");
        op_cmd(mk(PA, 0, 0), 1, "R8 ctl restored");
        op_cmd(mk(PA, 4, 0), 1, "R8 adv kept");
        op_cmd(mk(PA, 1, 0), 1, "R8 link kept across self reset");
        op_cmd(mk(4'h0, 0, 0), 1, "R2 foreign read no effect");
        op_data(16'h1234, 1);
        op_cmd(mk(4'h7, 4, 1), 1, "R2 foreign write");
        op_cmd(mk(PA, 4, 0), 1, "R2 adv untouched by foreign write");
        op_cmd(mk(PA, 2, 1), 1, "R11 id write ignored");
        op_cmd(mk(PA, 2, 0), 1, "R11 id still constant");
        op_cmd(mk(PA, 9, 0), 1, "R11 unknown read keeps data");
        op_cmd(mk(PA, 12, 1), 1, "R11 unknown write");
        op_cmd(mk(PA, 0, 0), 1, "R11 ctl unchanged");
        op_cmd(16'h1003, 1, "R1 busy cleared");
        for (int i = 0; i < 400; i++) begin
            int sel;
            bit lk;
            sel = $urandom_range(0, 9);
            lk = ($urandom_range(0, 3) == 0) ? ~m_link : m_link;
            if (sel < 3) op_data(16'($urandom), lk);
            else if (sel == 3) op_idle(lk);
            else op_cmd({($urandom_range(0, 3) == 0) ? 4'($urandom) : PA,
                         4'($urandom), 4'($urandom_range(0, 7)), 4'($urandom)},
                        lk, "R11 random mix");
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule